// File: doc/BRIEF.md
# Addressing Mode Address Generator

This block turns an operand specifier into an effective address for a two-operand machine whose instructions may take one operand from memory. A start strobe comes with a mode code, one or two register indices, a displacement or absolute value, the program counter of the instruction and an operand-size code. The block reads the named registers through a combinational register-file read port. It then returns the effective address with a one-cycle done pulse.

Immediate and register operands have no memory address. For these the block raises a no-address flag instead. The memory-indirect mode first fetches a pointer word over a simple request/ready memory port. The pre-decrement and post-increment modes also hand back a register write-back (index and new value) together with done, so the register file can apply the side effect exactly once.

Control is a three-state machine:
- `ST_IDLE` waits for start. With start, it goes to `ST_DONE` for every mode except memory-indirect, and to `ST_FETCH` for memory-indirect.
- `ST_FETCH` holds the memory request until ready is seen, then goes to `ST_DONE`.
- `ST_DONE` pulses done for one cycle and returns to `ST_IDLE`.

Top module: `eaddr_gen`

## Requirements
- R1: After reset, done, mem_req and wb_en are 0 and ea is 0.
- R2: Mode codes are: 0 immediate, 1 register, 2 absolute, 3 register-indirect, 4 memory-indirect, 5 indexed, 6 base+index, 7 base+index+offset, 8 PC-relative, 9 post-increment, 10 pre-decrement. Immediate and register modes give no_addr=1 and ea=0. All other defined modes give no_addr=0.
- R3: Each address is computed modulo 2^32, as follows:
  - absolute: ea = disp
  - register-indirect: ea = [ra]
  - indexed: ea = disp+[ra]
  - base+index: ea = [ra]+[rb]
  - base+index+offset: ea = [ra]+[rb]+disp
  - PC-relative: ea = pc+disp
- R4: For every mode except memory-indirect, done is high in the cycle after start is accepted. Done is a single-cycle pulse.
- R5: For memory-indirect, mem_req rises in the cycle after start, with mem_addr = disp. Both are held until mem_ready. Done then rises in the cycle after the ready cycle, with ea equal to the mem_rdata sampled with ready.
- R6: Post-increment gives ea = [ra]. Together with done it gives wb_en=1, wb_idx=ra and wb_data=[ra]+step.
- R7: Pre-decrement gives ea = [ra]-step. Together with done it gives wb_en=1, wb_idx=ra and wb_data equal to that same ea.
- R8: opsize selects the step: 00 gives 1, 01 gives 2, and 10 or 11 gives 4.
- R9: wb_en is high only for post-increment and pre-decrement, only in the done cycle, and only once per operation.
- R10: A start that arrives while an operation is in progress is ignored. It changes neither ea nor the done count.
- R11: Codes 11 to 15 behave like immediate: done after one cycle, no_addr=1, ea=0, no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Addressing mode code |
| ra_idx | input | RIW | First register index |
| rb_idx | input | RIW | Second register index |
| disp | input | AW | Displacement or absolute value |
| pc | input | AW | Program counter of the instruction |
| opsize | input | 2 | Operand size code |
| rf_ra_idx | output | RIW | Register-file read index A |
| rf_rb_idx | output | RIW | Register-file read index B |
| rf_ra_data | input | AW | Register-file read data A |
| rf_rb_data | input | AW | Register-file read data B |
| mem_req | output | 1 | Pointer fetch request |
| mem_addr | output | AW | Pointer fetch address |
| mem_ready | input | 1 | Pointer fetch data valid |
| mem_rdata | input | AW | Pointer fetch data |
| done | output | 1 | Result valid pulse |
| ea | output | AW | Effective address |
| no_addr | output | 1 | Operand has no memory address |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | RIW | Register write-back index |
| wb_data | output | AW | Register write-back value |

## Verification
The bench builds the block with AW=32 and RIW=3. The 32-bit width brings two checks within reach: an indexed sum that wraps past 2^32 back to a small value, and a negative PC-relative displacement given in two's complement. The 3-bit index gives eight registers, so post-increment and pre-decrement can be run back to back on the same register, with the bench's register model applying each write-back before the next operation. Within those settings the bench checks the worked numbers with registers holding 1200 and 4600, every step size, and a stray start during a stalled pointer fetch.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [3:0] {
        M_IMM  = 4'd0,
        M_REG  = 4'd1,
        M_ABS  = 4'd2,
        M_RIND = 4'd3,
        M_MIND = 4'd4,
        M_IDX  = 4'd5,
        M_BIX  = 4'd6,
        M_BIXO = 4'd7,
        M_REL  = 4'd8,
        M_AINC = 4'd9,
        M_ADEC = 4'd10
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } st_e;
endpackage

// File: rtl/eag_step.sv
module eag_step #(
    parameter int AW = 32
) (
    input  logic [1:0]    opsize,
    output logic [AW-1:0] step
);
    always_comb begin
        unique case (opsize)
            2'b00:   step = AW'(1);
            2'b01:   step = AW'(2);
            default: step = AW'(4);
        endcase
    end
endmodule

// File: rtl/eag_operand_sel.sv
module eag_operand_sel
    import eag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] ra_val,
    input  logic [AW-1:0] rb_val,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] ea_calc,
    output logic          no_addr,
    output logic          is_mind,
    output logic          wb_flag,
    output logic [AW-1:0] wb_val
);
    logic [AW-1:0] t0, t1, t2;
    mode_e m;

    assign m = mode_e'(mode);

    always_comb begin
        t0      = '0;
        t1      = '0;
        t2      = '0;
        no_addr = 1'b0;
        is_mind = 1'b0;
        wb_flag = 1'b0;
        wb_val  = '0;
        unique case (m)
            M_IMM:  no_addr = 1'b1;
            M_REG:  no_addr = 1'b1;
            M_ABS:  t0 = disp;
            M_RIND: t0 = ra_val;
            M_MIND: is_mind = 1'b1;
            M_IDX:  begin t0 = ra_val; t1 = disp; end
            M_BIX:  begin t0 = ra_val; t1 = rb_val; end
            M_BIXO: begin t0 = ra_val; t1 = rb_val; t2 = disp; end
            M_REL:  begin t0 = pc; t1 = disp; end
            M_AINC: begin
                t0      = ra_val;
                wb_flag = 1'b1;
                wb_val  = ra_val + step;
            end
            M_ADEC: begin
                t0      = ra_val;
                t1      = (~step) + AW'(1);
                wb_flag = 1'b1;
                wb_val  = ra_val - step;
            end
            default: no_addr = 1'b1;
        endcase
        ea_calc = t0 + t1 + t2;
    end
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
    import eag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_mind,
    input  logic mem_ready,
    output logic accept,
    output logic cap_mem,
    output logic done,
    output logic mem_req
);
    st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d    = st_q;
        accept  = 1'b0;
        cap_mem = 1'b0;
        done    = 1'b0;
        mem_req = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    accept = 1'b1;
                    st_d   = is_mind ? ST_FETCH : ST_DONE;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    cap_mem = 1'b1;
                    st_d    = ST_DONE;
                end
            end
            ST_DONE: begin
                done = 1'b1;
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/eaddr_gen.sv
module eaddr_gen
    import eag_pkg::*;
#(
    parameter int AW  = 32,
    parameter int RIW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [3:0]     mode,
    input  logic [RIW-1:0] ra_idx,
    input  logic [RIW-1:0] rb_idx,
    input  logic [AW-1:0]  disp,
    input  logic [AW-1:0]  pc,
    input  logic [1:0]     opsize,
    output logic [RIW-1:0] rf_ra_idx,
    output logic [RIW-1:0] rf_rb_idx,
    input  logic [AW-1:0]  rf_ra_data,
    input  logic [AW-1:0]  rf_rb_data,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_ready,
    input  logic [AW-1:0]  mem_rdata,
    output logic           done,
    output logic [AW-1:0]  ea,
    output logic           no_addr,
    output logic           wb_en,
    output logic [RIW-1:0] wb_idx,
    output logic [AW-1:0]  wb_data
);
    logic [AW-1:0] step, ea_calc, wb_val;
    logic          no_addr_c, is_mind, wb_flag_c;
    logic          accept, cap_mem;

    logic [AW-1:0]  ea_q, mem_addr_q, wb_data_q;
    logic           no_addr_q, wb_flag_q;
    logic [RIW-1:0] wb_idx_q;

    assign rf_ra_idx = ra_idx;
    assign rf_rb_idx = rb_idx;

    eag_step #(.AW(AW)) u_step (
        .opsize (opsize),
        .step   (step)
    );

    eag_operand_sel #(.AW(AW)) u_sel (
        .mode    (mode),
        .ra_val  (rf_ra_data),
        .rb_val  (rf_rb_data),
        .disp    (disp),
        .pc      (pc),
        .step    (step),
        .ea_calc (ea_calc),
        .no_addr (no_addr_c),
        .is_mind (is_mind),
        .wb_flag (wb_flag_c),
        .wb_val  (wb_val)
    );

    eag_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_mind   (is_mind),
        .mem_ready (mem_ready),
        .accept    (accept),
        .cap_mem   (cap_mem),
        .done      (done),
        .mem_req   (mem_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q       <= '0;
            mem_addr_q <= '0;
            no_addr_q  <= 1'b0;
            wb_flag_q  <= 1'b0;
            wb_idx_q   <= '0;
            wb_data_q  <= '0;
        end else begin
            if (accept) begin
                ea_q       <= is_mind ? '0 : ea_calc;
                mem_addr_q <= disp;
                no_addr_q  <= no_addr_c;
                wb_flag_q  <= wb_flag_c;
                wb_idx_q   <= ra_idx;
                wb_data_q  <= wb_val;
            end
            if (cap_mem) ea_q <= mem_rdata;
        end
    end

    assign ea       = ea_q;
    assign mem_addr = mem_addr_q;
    assign no_addr  = no_addr_q;
    assign wb_en    = done & wb_flag_q;
    assign wb_idx   = wb_idx_q;
    assign wb_data  = wb_data_q;
endmodule

// File: rtl/eaddr_gen_chk.sv
module eaddr_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    mode,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ready,
    input logic          done,
    input logic [AW-1:0] ea,
    input logic          no_addr,
    input logic          wb_en
);
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_start_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && !done && mode != 4'd4) |=> done);

    a_r5_start_to_req: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && !done && mode == 4'd4) |=> mem_req);

    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    a_r5_ready_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (done && !mem_req));

    a_r9_wb_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, mem_req}));

    a_r2_no_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_addr) |-> (ea == '0));
endmodule

bind eaddr_gen eaddr_gen_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .done      (done),
    .ea        (ea),
    .no_addr   (no_addr),
    .wb_en     (wb_en)
);

// File: tb/eaddr_gen_bench.sv
module eaddr_gen_bench;
    localparam int AW  = 32;
    localparam int RIW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [3:0]     mode = '0;
    logic [RIW-1:0] ra_idx = '0, rb_idx = '0;
    logic [AW-1:0]  disp = '0, pc = '0;
    logic [1:0]     opsize = '0;
    logic [RIW-1:0] rf_ra_idx, rf_rb_idx;
    logic [AW-1:0]  rf_ra_data, rf_rb_data;
    logic           mem_req, mem_ready = 1'b0;
    logic [AW-1:0]  mem_addr, mem_rdata = '0;
    logic           done, no_addr, wb_en;
    logic [AW-1:0]  ea, wb_data;
    logic [RIW-1:0] wb_idx;

    logic [AW-1:0]  regs [8];
    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    assign rf_ra_data = regs[rf_ra_idx];
    assign rf_rb_data = regs[rf_rb_idx];

    always @(posedge clk) if (wb_en) regs[wb_idx] <= wb_data;

    eaddr_gen #(.AW(AW), .RIW(RIW)) u_eaddr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .ra_idx(ra_idx), .rb_idx(rb_idx), .disp(disp), .pc(pc),
        .opsize(opsize), .rf_ra_idx(rf_ra_idx), .rf_rb_idx(rf_rb_idx),
        .rf_ra_data(rf_ra_data), .rf_rb_data(rf_rb_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .done(done), .ea(ea), .no_addr(no_addr),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Pulses start for one cycle; returns at the falling edge after the accepting edge.
    task automatic issue(input logic [3:0] m, input logic [RIW-1:0] a, input logic [RIW-1:0] b,
                         input logic [AW-1:0] d, input logic [AW-1:0] p, input logic [1:0] s);
        @(negedge clk);
        mode = m; ra_idx = a; rb_idx = b; disp = d; pc = p; opsize = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 done", AW'(done), 0);
        chk("R1 mem_req", AW'(mem_req), 0);
        chk("R1 wb_en", AW'(wb_en), 0);
        chk("R1 ea", ea, 0);
    endtask

    task automatic t_no_addr;
        issue(4'd0, 0, 0, 32'h55, 0, 0);
        chk("R2 imm done", AW'(done), 1);
        chk("R2 imm no_addr", AW'(no_addr), 1);
        chk("R2 imm ea", ea, 0);
        issue(4'd1, 3, 0, 0, 0, 0);
        chk("R2 reg no_addr", AW'(no_addr), 1);
        chk("R2 reg ea", ea, 0);
    endtask

    task automatic t_modes;
        issue(4'd2, 0, 0, 32'h1234, 0, 0);
        chk("R3 abs ea", ea, 32'h1234);
        chk("R2 abs no_addr", AW'(no_addr), 0);
        chk("R4 abs done", AW'(done), 1);
        @(negedge clk);
        chk("R4 done pulse ends", AW'(done), 0);
        issue(4'd3, 1, 0, 0, 0, 0);
        chk("R3 reg-indirect ea", ea, 1200);
        issue(4'd5, 1, 0, 20, 0, 0);
        chk("R3 indexed 20(R1)", ea, 1220);
        chk("R9 indexed no wb", AW'(wb_en), 0);
        issue(4'd6, 1, 2, 0, 0, 0);
        chk("R3 base+index", ea, 5800);
        issue(4'd7, 1, 2, 30, 0, 0);
        chk("R3 base+index+offset", ea, 5830);
        issue(4'd8, 0, 0, 32'hFFFF_FFF8, 32'h100, 0);
        chk("R3 relative", ea, 32'hF8);
        issue(4'd5, 3, 0, 2, 0, 0);
        chk("R3 wrap", ea, 1);
    endtask

    task automatic t_autoinc;
        issue(4'd9, 5, 0, 0, 0, 2'b10);
        chk("R6 ea", ea, 32'h2000);
        chk("R6 wb_en", AW'(wb_en), 1);
        chk("R6 wb_idx", AW'(wb_idx), 5);
        chk("R8 step 4 wb_data", wb_data, 32'h2004);
        @(negedge clk);
        chk("R9 wb once", AW'(wb_en), 0);
        chk("R6 reg updated", regs[5], 32'h2004);
    endtask

    task automatic t_autodec;
        issue(4'd10, 2, 0, 0, 0, 2'b00);
        chk("R7 -(R2) ea", ea, 4599);
        chk("R7 wb_data", wb_data, 4599);
        chk("R7 wb_en", AW'(wb_en), 1);
        issue(4'd10, 2, 0, 0, 0, 2'b01);
        chk("R8 step 2 ea", ea, 4597);
        issue(4'd10, 2, 0, 0, 0, 2'b11);
        chk("R8 step 4 code 11 ea", ea, 4593);
        chk("R7 wb_idx", AW'(wb_idx), 2);
    endtask

    task automatic t_mind;
        issue(4'd4, 0, 0, 32'h40, 0, 0);
        for (int k = 0; k < 3; k++) begin
            chk("R5 req held", AW'(mem_req), 1);
            chk("R5 req addr", mem_addr, 32'h40);
            chk("R5 no early done", AW'(done), 0);
            if (k == 1) begin
                mode = 4'd2; disp = 32'h777; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (k == 2) begin
                mem_ready = 1'b1; mem_rdata = 32'hCAFE_0000;
            end
            @(negedge clk);
        end
        mem_ready = 1'b0; start = 1'b0;
        chk("R5 done after ready", AW'(done), 1);
        chk("R5 ea from memory", ea, 32'hCAFE_0000);
        chk("R5 req dropped", AW'(mem_req), 0);
        @(negedge clk);
        chk("R10 no extra done", AW'(done), 0);
        chk("R10 ea kept", ea, 32'hCAFE_0000);
        @(negedge clk);
        chk("R10 still idle", AW'(done | mem_req), 0);
    endtask

    task automatic t_reserved;
        issue(4'd13, 4, 0, 32'h99, 0, 0);
        chk("R11 done", AW'(done), 1);
        chk("R11 no_addr", AW'(no_addr), 1);
        chk("R11 ea", ea, 0);
        chk("R11 no wb", AW'(wb_en), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL R5 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = '0;
        regs[1] = 1200;
        regs[2] = 4600;
        regs[3] = 32'hFFFF_FFFF;
        regs[5] = 32'h2000;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_no_addr();
        t_modes();
        t_autoinc();
        t_autodec();
        t_mind();
        t_reserved();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule